// File: doc/BRIEF.md
# Tear-Resistant Monotonic Counter Bank

This block holds a small bank of 24-bit counters that only ever move upward and that survive a power loss in the middle of an update. Each counter is kept as a pair of nonvolatile slots. A slot holds a value and an 8-bit marker, and it is trusted only when the marker carries the one valid code. An update never writes over the slot that is currently in use. It writes the sum into the other slot through a slow, timed sequence. If power is cut before that sequence ends, the slot in use still holds the last good value.

Software sees three commands, each addressed by a counter index. It can read a counter, it can add an amount to a counter, and it can ask whether the latest update of a counter ran to completion. The slots themselves cannot be read. An `abort` input stands for the supply vanishing partway through an update. The nonvolatile cells are modelled as registers, and each write phase lasts a fixed number of cycles.

Top module: `tear_counter_bank`

## Requirements
- R1: After reset every counter reads 0, and a tear check on every counter returns 0xBD.
- R2: The command codes are 2'b00 read, 2'b01 increment and 2'b10 tear check. Code 2'b11, or a counter index of 3 or more, gives a response one cycle after acceptance with `rsp_err`=1 and `rsp_data`=0.
- R3: A read is accepted when `cmd_valid` is high and `busy` is low. One cycle later `rsp_valid` pulses with `rsp_err`=0 and the resolved counter value, and `busy` stays low.
- R4: An accepted increment holds `busy` high for exactly 3×PHASE_CYC cycles. `rsp_valid` pulses in the cycle that `busy` falls, carrying the new value. Later reads return that new value.
- R5: An increment whose sum would exceed 0xFFFFFF is refused. One cycle later the response has `rsp_err`=1. `busy` never rises, and the counter keeps its value.
- R6: A slot is valid only when its marker equals 0xBD. A read returns the larger value when both slots are valid, and the only valid value otherwise. An increment writes the selected value plus its argument into the other slot, so an argument of 0 copies the value.
- R7: `abort` high while `busy` ends the update at that edge, in any phase, and no response follows. Reads then return the value from before the increment, and at least one slot of every counter stays valid.
- R8: A tear check returns, in `rsp_data[7:0]`, the marker of the slot written most recently for that counter. This is 0xBD after a completed increment and 0x00 after a torn one. The upper bits are zero.
- R9: `cmd_valid` while `busy` is high is dropped without a response. `abort` while idle has no effect.
- R10: The three counters are independent of each other. An operation on one changes neither the value nor the tear status of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_idx | input | 2 | Counter index |
| cmd_arg | input | 24 | Increment amount |
| abort | input | 1 | Field-loss event that cuts a running update short |
| busy | output | 1 | A slot update is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | 24 | Counter value, or the marker in bits 7:0 |

## Verification
The assertions assume a command is presented with `cmd_valid` for one cycle, and that `abort` is meaningful only while an update runs. The stimulus therefore lowers `cmd_valid` after one clock and raises `abort` only for single cycles, timed to land in the erase, value and marker phases. They also assume the indexed counter's operands are stable at acceptance. The bench drives every input at the falling edge, so each value is settled when the rising edge samples it.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_INCR = 2'd1,
    OP_TEAR = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_VALUE = 2'd2,
    PH_FLAG  = 2'd3
  } phase_e;

  localparam logic [7:0] MARK_GOOD  = 8'hBD;
  localparam logic [7:0] MARK_BLANK = 8'h00;
endpackage

// File: rtl/tcb_rst_sync.sv
module tcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tcb_resolve.sv
module tcb_resolve #(
  parameter int CW = 24
) (
  input  logic [CW-1:0] val0,
  input  logic [7:0]    mark0,
  input  logic [CW-1:0] val1,
  input  logic [7:0]    mark1,
  output logic          any_ok,
  output logic          sel,
  output logic [CW-1:0] value
);
  import tcb_pkg::*;

  logic ok0, ok1;

  always_comb begin
    ok0    = (mark0 == MARK_GOOD);
    ok1    = (mark1 == MARK_GOOD);
    any_ok = ok0 | ok1;
    // both good: larger wins, slot 1 on a tie
    if (ok0 && ok1) sel = (val0 > val1) ? 1'b0 : 1'b1;
    else            sel = ok0 ? 1'b0 : 1'b1;
    value = any_ok ? (sel ? val1 : val0) : '0;
  end
endmodule

// File: rtl/tcb_wr_seq.sv
module tcb_wr_seq #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic erase_done,
  output logic value_done,
  output logic mark_done
);
  import tcb_pkg::*;

  localparam int TW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  phase_e        ph_q, ph_d;
  logic [TW-1:0] tick_q, tick_d;
  logic          last;

  always_comb begin
    last   = (tick_q == TW'(PHASE_CYC - 1));
    ph_d   = ph_q;
    tick_d = tick_q;
    if (ph_q == PH_IDLE) begin
      if (start) begin
        ph_d   = PH_ERASE;
        tick_d = '0;
      end
    end else if (abort) begin
      ph_d   = PH_IDLE;
      tick_d = '0;
    end else if (last) begin
      tick_d = '0;
      case (ph_q)
        PH_ERASE: ph_d = PH_VALUE;
        PH_VALUE: ph_d = PH_FLAG;
        default:  ph_d = PH_IDLE;
      endcase
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      tick_q <= '0;
    end else begin
      ph_q   <= ph_d;
      tick_q <= tick_d;
    end
  end

  assign busy       = (ph_q != PH_IDLE);
  assign erase_done = (ph_q == PH_ERASE) && last && !abort;
  assign value_done = (ph_q == PH_VALUE) && last && !abort;
  assign mark_done  = (ph_q == PH_FLAG)  && last && !abort;
endmodule

// File: rtl/tear_counter_bank.sv
module tear_counter_bank #(
  parameter int NCNT      = 3,
  parameter int CW        = 24,
  parameter int PHASE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [1:0]    cmd_idx,
  input  logic [CW-1:0] cmd_arg,
  input  logic          abort,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [CW-1:0] rsp_data
);
  import tcb_pkg::*;

  logic rst_sync_n;
  logic erase_done, value_done, mark_done, start;

  logic [CW-1:0] slot_val  [NCNT][2];
  logic [7:0]    slot_mark [NCNT][2];
  logic [NCNT-1:0] last_wr;
  logic [NCNT-1:0] any_ok, cur_sel;
  logic [CW-1:0] cur_val [NCNT];

  logic [1:0]    tgt_idx_q;
  logic          tgt_slot_q;
  logic [CW-1:0] new_val_q;

  logic          accept, idx_ok, ovf, sel_bit;
  logic [CW-1:0] sel_val;
  logic [7:0]    tear_mark;
  logic [CW:0]   sum;
  logic          rsp_valid_d, rsp_err_d;
  logic [CW-1:0] rsp_data_d;

  tcb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  tcb_wr_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .abort(abort),
    .busy(busy), .erase_done(erase_done), .value_done(value_done),
    .mark_done(mark_done)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_res
    tcb_resolve #(.CW(CW)) u_res (
      .val0(slot_val[g][0]), .mark0(slot_mark[g][0]),
      .val1(slot_val[g][1]), .mark1(slot_mark[g][1]),
      .any_ok(any_ok[g]), .sel(cur_sel[g]), .value(cur_val[g])
    );
  end

  // command decode against the addressed counter
  always_comb begin
    accept    = cmd_valid && !busy;
    idx_ok    = (int'(cmd_idx) < NCNT);
    sel_val   = '0;
    sel_bit   = 1'b0;
    tear_mark = MARK_GOOD;
    for (int i = 0; i < NCNT; i++) begin
      if (int'(cmd_idx) == i) begin
        sel_val   = cur_val[i];
        sel_bit   = cur_sel[i];
        tear_mark = slot_mark[i][last_wr[i]];
      end
    end
    sum   = {1'b0, sel_val} + {1'b0, cmd_arg};
    ovf   = sum[CW];
    start = accept && idx_ok && (cmd_op == OP_INCR) && !ovf;
  end

  // update target latched at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_idx_q  <= '0;
      tgt_slot_q <= 1'b0;
      new_val_q  <= '0;
    end else if (!rst_sync_n) begin
      tgt_idx_q  <= '0;
      tgt_slot_q <= 1'b0;
      new_val_q  <= '0;
    end else if (start) begin
      tgt_idx_q  <= cmd_idx;
      tgt_slot_q <= ~sel_bit;
      new_val_q  <= sum[CW-1:0];
    end
  end

  // nonvolatile slot model
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NCNT; i++) begin
        for (int s = 0; s < 2; s++) begin
          slot_val[i][s]  <= '0;
          slot_mark[i][s] <= MARK_GOOD;
        end
      end
      last_wr <= '1;
    end else begin
      if (start) begin
        slot_mark[cmd_idx][~sel_bit] <= MARK_BLANK;
        last_wr[cmd_idx]             <= ~sel_bit;
      end
      if (erase_done) slot_val[tgt_idx_q][tgt_slot_q]  <= '0;
      if (value_done) slot_val[tgt_idx_q][tgt_slot_q]  <= new_val_q;
      if (mark_done)  slot_mark[tgt_idx_q][tgt_slot_q] <= MARK_GOOD;
    end
  end

  // response next state
  always_comb begin
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_data_d  = '0;
    if (mark_done) begin
      rsp_valid_d = 1'b1;
      rsp_data_d  = new_val_q;
    end else if (accept) begin
      if (!idx_ok || cmd_op == OP_RSVD || (cmd_op == OP_INCR && ovf)) begin
        rsp_valid_d = 1'b1;
        rsp_err_d   = 1'b1;
      end else if (cmd_op == OP_READ) begin
        rsp_valid_d = 1'b1;
        rsp_data_d  = sel_val;
      end else if (cmd_op == OP_TEAR) begin
        rsp_valid_d = 1'b1;
        rsp_data_d  = {{(CW-8){1'b0}}, tear_mark};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rsp_data  <= rsp_data_d;
    end
  end
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int NCNT = 3,
  parameter int CW   = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [1:0]      cmd_idx,
  input logic [CW-1:0]   cmd_arg,
  input logic            abort,
  input logic            busy,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [CW-1:0]   rsp_data,
  input logic [NCNT-1:0] any_ok,
  input logic [CW-1:0]   sel_val
);
  logic idx_in, acc;
  logic [CW:0] total;

  always_comb begin
    idx_in = (int'(cmd_idx) < NCNT);
    acc    = cmd_valid && !busy;
    total  = {1'b0, sel_val} + {1'b0, cmd_arg};
  end

  assert_bad_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (!idx_in || cmd_op == 2'd3) |=> rsp_valid && rsp_err && rsp_data == '0);

  assert_read_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && idx_in && cmd_op == 2'd0 |=> rsp_valid && !rsp_err && !busy);

  assert_busy_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_op == 2'd1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && idx_in && cmd_op == 2'd1 && total[CW] |=> rsp_valid && rsp_err && !busy);

  assert_abort_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy && !rsp_valid);

  assert_slot_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_ok == {NCNT{1'b1}});
endmodule

bind tear_counter_bank tcb_checker #(.NCNT(NCNT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .abort(abort), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .any_ok(any_ok), .sel_val(sel_val)
);

// File: tb/test_tear_counter_bank.sv
module test_tear_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, abort;
  logic [1:0]  cmd_op, cmd_idx;
  logic [23:0] cmd_arg;
  logic        busy, rsp_valid, rsp_err;
  logic [23:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tear_counter_bank #(.NCNT(3), .CW(24), .PHASE_CYC(PH)) i_tear_counter_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .abort(abort), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  idx;
    logic [23:0] arg;
    logic        err;
    logic [23:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{2'd0, 2'd0, 24'h0,      1'b0, 24'h0,      8'd1},  // R1 read at reset
    '{2'd1, 2'd0, 24'h123,    1'b0, 24'h123,    8'd4},  // R4
    '{2'd1, 2'd0, 24'h1,      1'b0, 24'h124,    8'd6},  // R6 larger slot used
    '{2'd0, 2'd0, 24'h0,      1'b0, 24'h124,    8'd3},  // R3
    '{2'd2, 2'd0, 24'h0,      1'b0, 24'hBD,     8'd8},  // R8
    '{2'd1, 2'd1, 24'hFFFFFE, 1'b0, 24'hFFFFFE, 8'd4},  // R4
    '{2'd1, 2'd1, 24'h1,      1'b0, 24'hFFFFFF, 8'd4},  // R4 reaches top
    '{2'd1, 2'd1, 24'h1,      1'b1, 24'h0,      8'd5},  // R5 refused
    '{2'd0, 2'd1, 24'h0,      1'b0, 24'hFFFFFF, 8'd5},  // R5 unchanged
    '{2'd0, 2'd2, 24'h0,      1'b0, 24'h0,      8'd10}, // R10
    '{2'd3, 2'd0, 24'h0,      1'b1, 24'h0,      8'd2},  // R2 reserved op
    '{2'd0, 2'd3, 24'h0,      1'b1, 24'h0,      8'd2},  // R2 bad index
    '{2'd1, 2'd2, 24'h0,      1'b0, 24'h0,      8'd6},  // R6 copy by zero
    '{2'd0, 2'd0, 24'h0,      1'b0, 24'h124,    8'd10}  // R10 counter 0 kept
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] idx, input logic [23:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [1:0] idx, input logic [23:0] arg,
                         output logic got, output logic err, output logic [23:0] data);
    issue(op, idx, arg);
    while (busy) @(negedge clk);
    got = rsp_valid; err = rsp_err; data = rsp_data;
  endtask

  task automatic torn_incr(input int cut, input string req);
    int seen;
    issue(2'd1, 2'd0, 24'h1);
    seen = 1;
    while (seen < cut) begin @(negedge clk); seen++; end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(!busy && !rsp_valid, req, "abort ends update silently", {busy, rsp_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic g, e;
    logic [23:0] d;
    int pulses, busy_cyc;
    rst_n = 1'b0; cmd_valid = 1'b0; abort = 1'b0;
    cmd_op = 2'd0; cmd_idx = 2'd0; cmd_arg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!busy && !rsp_valid, "R1", "idle after reset", {busy, rsp_valid}, 0);
    run_cmd(2'd2, 2'd1, 0, g, e, d);
    check(g && !e && d == 24'hBD, "R1", "tear mark after reset", d, 24'hBD);

    foreach (VEC[k]) begin
      run_cmd(VEC[k].op, VEC[k].idx, VEC[k].arg, g, e, d);
      checks++;
      if (!g || e !== VEC[k].err || d !== VEC[k].data) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=0x%0h/%0b expected=0x%0h/%0b",
                 VEC[k].req, k, d, e, VEC[k].data, VEC[k].err);
      end
    end

    // R7 / R8 abort in each phase of counter 0 (value 0x124)
    torn_incr(2, "R7");                 // erase phase
    run_cmd(2'd0, 2'd0, 0, g, e, d);
    check(d == 24'h124, "R7", "read after erase-phase tear", d, 24'h124);
    run_cmd(2'd2, 2'd0, 0, g, e, d);
    check(d == 24'h00, "R8", "mark after tear", d, 24'h00);
    run_cmd(2'd2, 2'd1, 0, g, e, d);
    check(d == 24'hBD, "R10", "other counter mark untouched", d, 24'hBD);
    torn_incr(6, "R7");                 // value phase
    run_cmd(2'd0, 2'd0, 0, g, e, d);
    check(d == 24'h124, "R7", "read after value-phase tear", d, 24'h124);
    torn_incr(10, "R7");                // marker phase
    run_cmd(2'd0, 2'd0, 0, g, e, d);
    check(d == 24'h124, "R7", "read after marker-phase tear", d, 24'h124);
    run_cmd(2'd2, 2'd0, 0, g, e, d);
    check(d == 24'h00, "R8", "mark after late tear", d, 24'h00);

    // R6 recovery: increment onto the torn slot
    run_cmd(2'd1, 2'd0, 24'h1, g, e, d);
    check(g && d == 24'h125, "R6", "increment after tear", d, 24'h125);
    run_cmd(2'd2, 2'd0, 0, g, e, d);
    check(d == 24'hBD, "R8", "mark after completed update", d, 24'hBD);

    // R4 / R9 busy length and dropped command
    issue(2'd1, 2'd2, 24'h7);
    pulses = 0; busy_cyc = 0;
    while (busy) begin
      busy_cyc++;
      if (busy_cyc == 3) cmd_valid = 1'b1;
      else cmd_valid = 1'b0;
      cmd_op = 2'd0; cmd_idx = 2'd1;
      if (rsp_valid) pulses++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(busy_cyc == 3*PH, "R4", "busy cycles", busy_cyc, 3*PH);
    check(rsp_valid && rsp_data == 24'h7 && pulses == 0, "R9", "single response",
          {rsp_data, 8'(pulses)}, {24'h7, 8'd0});
    @(negedge clk);
    check(!rsp_valid, "R9", "no late response for dropped read", rsp_valid, 0);

    // R9 abort while idle
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(!busy && !rsp_valid, "R9", "idle abort quiet", {busy, rsp_valid}, 0);
    run_cmd(2'd0, 2'd0, 0, g, e, d);
    check(d == 24'h125, "R9", "value kept after idle abort", d, 24'h125);
    run_cmd(2'd2, 2'd0, 0, g, e, d);
    check(d == 24'hBD, "R9", "mark kept after idle abort", d, 24'hBD);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule